// File: doc/BRIEF.md
# Turbine Vane Pulse Meter

This block turns the two optical sensor outputs of a rotating-vane flow turbine into a signed pulse count and a pulse-to-pulse interval. The sensor signals are slow square waves that sit a quarter cycle apart. The sign of that offset gives the direction of airflow. The vane breaks each beam twice per turn. The number of pulses therefore tracks the volume of air that has passed, and the rate of pulses tracks the flow.

Each sensor line first passes through a two-stage synchroniser. A glitch filter follows, and its length is set by a configuration input. Only the rising edge of the filtered A channel is counted. The level of the filtered B channel at that edge selects up or down. A free-running prescaler produces a time tick. The number of ticks between two counted edges is latched as the period. Software then divides a constant by that period to get flow. If no counted edge arrives before a programmable number of ticks, the block reports a stall (zero flow).

A small host port reads the count, the period and the status, and accepts a clear command. Volume and flow scaling are left to software.

Top module: `turb_meter`

## Requirements
- R1: Each pin passes through a two-flop synchroniser and then a filter. After synchronisation, a new level must persist for more than `cfg_filt_len` clock cycles before the filtered level follows it. Shorter pulses are ignored.
- R2: Only the rising edge of filtered channel A changes the count. With filtered B low at that edge, the count rises by one. With B high, it falls by one. Falling A edges and any B activity leave the count unchanged.
- R3: The count is a signed `COUNT_W`-bit value (24 by default). It saturates at the largest positive and most negative values instead of wrapping.
- R4: The period register holds the number of prescaler ticks (one every `TICK_DIV` clocks) between the two most recent counted edges.
- R5: When `cfg_timeout` ticks pass with no counted edge, the period register becomes all ones and the stalled flag is set.
- R6: The first counted edge after a stall clears the stalled flag and leaves the period at all ones. The next edge latches a real interval.
- R7: Writing address 3 with `bus_wdata` = 1 zeroes the count and the period and clears the stalled flag, effective the next cycle. A count read issued in the same cycle returns the value from before the clear. Writing 0 to address 3 has no effect.
- R8: A read issued with `bus_rd` returns its data on `bus_rdata` one cycle later. Address 0 returns the count sign-extended to 32 bits. Address 1 returns the period zero-extended. Address 2 returns bit 0 = direction of the last counted edge (1 = down) and bit 1 = stalled. `bus_rdata` holds its value while no read is issued.
- R9: After reset the count is 0, the period is all ones, the stalled flag is 1 and the direction is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Sensor channel A (asynchronous) |
| pin_b | input | 1 | Sensor channel B (asynchronous) |
| cfg_filt_len | input | FILT_W | Glitch filter length in clock cycles |
| cfg_timeout | input | PER_W | Stall timeout in ticks |
| bus_raddr | input | 2 | Read address |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| bus_waddr | input | 2 | Write address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 1 | Write data (clear command bit) |

## Verification
The bench drives forward and reverse quadrature bursts with random phase hold times and pulse counts. It checks the count, the direction and the tick-exact period after every burst. Two kinds of stimulus show that only the A rising edge counts: glitches shorter than the filter, and B-only toggles. One tells filtering apart from edge selection, the other tells edge selection apart from level sensing. Long runs in each direction push a narrowed counter into both limits. An idle gap followed by one and then two pulses separates the stall, restart and normal-period behaviours. A read issued together with a clear shows the pre-clear count.

// File: rtl/turb_pkg.sv
package turb_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_PERIOD = 2'd1,
        REG_STATUS = 2'd2,
        REG_CTRL   = 2'd3
    } reg_addr_e;

    // One counting event derived from the filtered channels
    typedef struct packed {
        logic valid;
        logic down;
    } step_t;

    function automatic step_t make_step(input logic a_rise, input logic b_level);
        step_t s;
        s.valid = a_rise;
        s.down  = b_level;
        return s;
    endfunction

endpackage

// File: rtl/turb_deglitch.sv
module turb_deglitch #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin,
    input  logic [FILT_W-1:0] filt_len,
    output logic              level
);
    logic [1:0]        sync_q;
    logic              stable_q;
    logic [FILT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            stable_q <= 1'b0;
            run_q    <= '0;
        end else begin
            sync_q <= {sync_q[0], pin};
            if (sync_q[1] == stable_q) begin
                run_q <= '0;
            end else if (run_q >= filt_len) begin
                stable_q <= sync_q[1];
                run_q    <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign level = stable_q;

    // R1: filtered level only ever moves to the synchronised level
    p_filt_follow_r1: assert property (@(posedge clk) disable iff (rst)
        (stable_q != $past(stable_q)) |-> (stable_q == $past(sync_q[1])));

    // R1: while the run is shorter than the filter, the level holds
    p_filt_hold_r1: assert property (@(posedge clk) disable iff (rst)
        ((sync_q[1] != stable_q) && (run_q < filt_len)) |=> $stable(stable_q));

endmodule

// File: rtl/turb_step_count.sv
module turb_step_count
    import turb_pkg::*;
#(
    parameter int COUNT_W = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  step_t                     step,
    output logic signed [COUNT_W-1:0] count,
    output logic                      dir_down
);
    localparam logic signed [COUNT_W-1:0] CMAX = {1'b0, {(COUNT_W-1){1'b1}}};
    localparam logic signed [COUNT_W-1:0] CMIN = {1'b1, {(COUNT_W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            dir_down <= 1'b0;
        end else if (clr) begin
            count <= '0;
        end else if (step.valid) begin
            dir_down <= step.down;
            if (step.down) begin
                if (count != CMIN) count <= count - 1'b1;
            end else begin
                if (count != CMAX) count <= count + 1'b1;
            end
        end
    end

    // R2: no counting event, no change
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !step.valid) |=> $stable(count));

    // R3: no wrap from top to bottom
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (count == CMAX && !clr) |=> (count != CMIN));

    // R3: no wrap from bottom to top
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (count == CMIN && !clr) |=> (count != CMAX));

endmodule

// File: rtl/turb_interval.sv
module turb_interval #(
    parameter int PER_W    = 16,
    parameter int TICK_DIV = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             edge_evt,
    input  logic [PER_W-1:0] timeout,
    output logic [PER_W-1:0] period,
    output logic             stalled
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PER_W-1:0] run_q;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            run_q   <= '0;
            period  <= '1;
            stalled <= 1'b1;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (clr) begin
                run_q   <= PER_W'(tick);
                period  <= '0;
                stalled <= 1'b0;
            end else if (edge_evt) begin
                period  <= stalled ? '1 : run_q;
                run_q   <= PER_W'(tick);
                stalled <= 1'b0;
            end else if (!stalled && run_q >= timeout) begin
                period  <= '1;
                stalled <= 1'b1;
            end else if (!stalled && tick) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R5: a stall always shows an all-ones period
    p_stall_ones_r5: assert property (@(posedge clk) disable iff (rst)
        stalled |-> (period == '1));

    // R6: a counted edge ends any stall
    p_edge_unstall_r6: assert property (@(posedge clk) disable iff (rst)
        (edge_evt && !clr) |=> !stalled);

    // R6: edge while stalled keeps period saturated
    p_restart_ones_r6: assert property (@(posedge clk) disable iff (rst)
        (edge_evt && !clr && stalled) |=> (period == '1));

endmodule

// File: rtl/turb_meter.sv
module turb_meter
    import turb_pkg::*;
#(
    parameter int COUNT_W  = 24,
    parameter int PER_W    = 16,
    parameter int FILT_W   = 4,
    parameter int TICK_DIV = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic [FILT_W-1:0] cfg_filt_len,
    input  logic [PER_W-1:0]  cfg_timeout,
    input  logic [1:0]        bus_raddr,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [1:0]        bus_waddr,
    input  logic              bus_wr,
    input  logic              bus_wdata
);
    localparam int NCH = 2;

    logic [NCH-1:0] pins;
    logic [NCH-1:0] lvl;
    logic           a_prev_q;
    logic           a_rise;
    logic           clr;
    step_t          step;

    logic signed [COUNT_W-1:0] count;
    logic                      dir_down;
    logic [PER_W-1:0]          period;
    logic                      stalled;

    assign pins = {pin_b, pin_a};

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        turb_deglitch #(.FILT_W(FILT_W)) u_dg (
            .clk      (clk),
            .rst      (rst),
            .pin      (pins[g]),
            .filt_len (cfg_filt_len),
            .level    (lvl[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) a_prev_q <= 1'b0;
        else     a_prev_q <= lvl[0];
    end

    assign a_rise = lvl[0] & ~a_prev_q;
    assign step   = make_step(a_rise, lvl[1]);
    assign clr    = bus_wr && (reg_addr_e'(bus_waddr) == REG_CTRL) && bus_wdata;

    turb_step_count #(.COUNT_W(COUNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .step     (step),
        .count    (count),
        .dir_down (dir_down)
    );

    turb_interval #(.PER_W(PER_W), .TICK_DIV(TICK_DIV)) u_per (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .edge_evt (step.valid),
        .timeout  (cfg_timeout),
        .period   (period),
        .stalled  (stalled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (reg_addr_e'(bus_raddr))
                REG_COUNT:  bus_rdata <= {{(BUS_W-COUNT_W){count[COUNT_W-1]}}, count};
                REG_PERIOD: bus_rdata <= {{(BUS_W-PER_W){1'b0}}, period};
                REG_STATUS: bus_rdata <= {{(BUS_W-2){1'b0}}, stalled, dir_down};
                default:    bus_rdata <= '0;
            endcase
        end
    end

    // R7: clear takes effect on the following cycle
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && period == '0 && !stalled));

    // R8: read data is held between reads
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R2: B activity alone never moves the count
    p_b_only_r2: assert property (@(posedge clk) disable iff (rst)
        (!a_rise && !clr) |=> $stable(count));

endmodule

// File: tb/test_turb_meter.sv
module test_turb_meter;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 6;
    localparam int PW   = 16;
    localparam int FW   = 4;
    localparam int DIV  = 4;
    localparam int CMAX = 31;
    localparam int CMIN = -32;
    localparam int TMO  = 50;

    logic          clk = 1'b0;
    logic          rst;
    logic          pin_a, pin_b;
    logic [FW-1:0] cfg_filt_len;
    logic [PW-1:0] cfg_timeout;
    logic [1:0]    bus_raddr, bus_waddr;
    logic          bus_rd, bus_wr, bus_wdata;
    logic [31:0]   bus_rdata;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    bit exp_dir = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    turb_meter #(.COUNT_W(CW), .PER_W(PW), .FILT_W(FW), .TICK_DIV(DIV)) i_turb_meter (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b),
        .cfg_filt_len(cfg_filt_len), .cfg_timeout(cfg_timeout),
        .bus_raddr(bus_raddr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_waddr(bus_waddr), .bus_wr(bus_wr), .bus_wdata(bus_wdata)
    );

    function automatic int sat(input int v);
        if (v > CMAX) return CMAX;
        if (v < CMIN) return CMIN;
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_raddr = a;
        bus_rd    = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic d);
        @(negedge clk);
        bus_waddr = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_pins(input logic a, input logic b, input int h);
        @(negedge clk);
        pin_a = a;
        pin_b = b;
        repeat (h - 1) @(negedge clk);
    endtask

    task automatic spin(input int n, input bit rev, input int h);
        for (int i = 0; i < n; i++) begin
            if (!rev) begin
                set_pins(1, 0, h); set_pins(1, 1, h); set_pins(0, 1, h); set_pins(0, 0, h);
            end else begin
                set_pins(0, 1, h); set_pins(1, 1, h); set_pins(1, 0, h); set_pins(0, 0, h);
            end
            exp_cnt = sat(exp_cnt + (rev ? -1 : 1));
            exp_dir = rev;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        pin_a = 0; pin_b = 0;
        cfg_filt_len = FW'(2);
        cfg_timeout  = PW'(TMO);
        bus_raddr = 0; bus_waddr = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        reg_read(2'd0, v); check("R9 count", v, 32'd0);
        reg_read(2'd1, v); check("R9 period", v, 32'h0000FFFF);
        reg_read(2'd2, v); check("R9 status", v, 32'd2);

        // R6 first edge after stall keeps ones, second gives interval
        spin(1, 0, 5);
        reg_read(2'd1, v); check("R6 period after restart", v, 32'h0000FFFF);
        reg_read(2'd2, v); check("R6 stall cleared", v, 32'd0);
        spin(2, 0, 6);
        reg_read(2'd1, v); check("R4 period after restart", v, 32'd6);
        reg_read(2'd0, v); check("R2 forward count", v, 32'(exp_cnt));

        // R2/R4/R8 random bursts
        for (int k = 0; k < 10; k++) begin
            int n, h;
            bit rev;
            n   = $urandom_range(6, 1);
            h   = $urandom_range(12, 3);
            rev = 1'($urandom_range(1, 0));
            spin(n, rev, h);
            reg_read(2'd0, v); check("R2 burst count", v, 32'(exp_cnt));
            reg_read(2'd2, v); check("R8 burst status", v, {30'd0, 1'b0, exp_dir});
            if (n >= 2) begin
                reg_read(2'd1, v); check("R4 burst period", v, 32'(h));
            end
        end

        // R1 short glitch on A (3 cycles with filter 3) ignored
        cfg_filt_len = FW'(3);
        repeat (4) @(negedge clk);
        set_pins(1, 0, 3);
        set_pins(0, 0, 12);
        reg_read(2'd0, v); check("R1 glitch ignored", v, 32'(exp_cnt));
        // R1 a pulse long enough is accepted
        set_pins(1, 0, 6);
        set_pins(0, 0, 12);
        exp_cnt = sat(exp_cnt + 1);
        reg_read(2'd0, v); check("R1 long pulse counted", v, 32'(exp_cnt));
        cfg_filt_len = FW'(2);

        // R2 B-only toggles ignored
        for (int i = 0; i < 4; i++) begin
            set_pins(0, 1, 6);
            set_pins(0, 0, 6);
        end
        repeat (10) @(negedge clk);
        reg_read(2'd0, v); check("R2 B toggles ignored", v, 32'(exp_cnt));

        // R5 stall after idle
        repeat (TMO * DIV + 40) @(negedge clk);
        reg_read(2'd2, v); check("R5 stalled flag", v[1], 32'd1);
        reg_read(2'd1, v); check("R5 period saturated", v, 32'h0000FFFF);

        // R7 clear with simultaneous count read
        spin(3, 0, 4);
        @(negedge clk);
        bus_raddr = 2'd0; bus_rd = 1'b1;
        bus_waddr = 2'd3; bus_wdata = 1'b1; bus_wr = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check("R7 read returns pre-clear count", bus_rdata, 32'(exp_cnt));
        exp_cnt = 0;
        reg_read(2'd0, v); check("R7 count zeroed", v, 32'd0);
        reg_read(2'd1, v); check("R7 period zeroed", v, 32'd0);
        reg_read(2'd2, v); check("R7 stall cleared", v[1], 32'd0);
        spin(2, 0, 3);
        reg_write(2'd3, 1'b0);
        reg_read(2'd0, v); check("R7 write of zero ignored", v, 32'd2);
        reg_write(2'd3, 1'b1);
        exp_cnt = 0;

        // R3 saturation at both ends
        spin(35, 0, 3);
        reg_read(2'd0, v); check("R3 positive limit", v, 32'(CMAX));
        spin(70, 1, 3);
        reg_read(2'd0, v); check("R3 negative limit", v, 32'(CMIN));
        reg_read(2'd2, v); check("R8 down direction", v, 32'd1);

        finish_run();
    end
endmodule